// File: doc/BRIEF.md
# Down-Counting Watchdog with Reset-Cause Flag

This block is a watchdog timer for a small microcontroller. A 7-bit count and an enable latch share one control byte that the CPU writes over its bus. Once the watchdog is active, a prescaler steps the count down once every `PRESCALE` CPU clocks. When count bit 6 falls, the block raises a one-cycle system reset request. Software keeps the chip alive by rewriting the control byte with a value from C0h to FFh before that happens. With the default `PRESCALE` of 12288 and an 8 MHz clock, the window runs from 1.536 ms to 98.304 ms.

There are three more ways to get a reset request: a control write that clears bit 6 while the watchdog is enabled, a HALT strobe while it is active, and a static hardware option input that keeps the watchdog active whatever the enable bit holds. A status byte keeps a flag that records a watchdog reset. An external system reset leaves this flag alone, so boot code can tell the reset causes apart. Only power-on reset or a software write clears it.

The block has no streaming data path. All pins are plain control and status signals. A register write is a single-cycle strobe that always takes effect, so there is no back-pressure.

Top module: `wdt_downcount`

## Requirements
- R1: After power-on reset, `ctrl_q` reads 7Fh, `stat_q` reads 00h and `wdg_rst` is 0.
- R2: Control bit 7 is the enable. A write with bit 7 = 1 sets it. A write with bit 7 = 0 does not clear it. Only a reset clears it.
- R3: A control write loads bits 6:0 into the count and restarts the prescaler. While the watchdog is inactive, the count holds its value.
- R4: While the watchdog is active (enable set or `hw_opt` high), the count drops by one every `PRESCALE` clocks. The first step comes `PRESCALE` clocks after the write.
- R5: When the count steps from 40h to 3Fh, a request is raised. After a write of count T (40h..7Fh), `wdg_rst` rises on the clock edge `PRESCALE*(T-63)` cycles after the write edge.
- R6: If a control write leaves the watchdog enabled and has bit 6 = 0, `wdg_rst` is 1 in the cycle after the write. A write with bits 7 and 6 both 0 while disabled raises nothing.
- R7: `halt_stb` high while the watchdog is active gives `wdg_rst` = 1 in the next cycle. While inactive, it has no effect.
- R8: With `hw_opt` high, the count runs and expires even though the enable bit reads 0.
- R9: `wdg_rst` is a registered pulse. For a single trigger it is high for exactly one cycle.
- R10: `stat_q` bit 0 is set by a reset request. It survives `rst_n`. It is cleared by `por_n` or by a status write with bit 0 = 0. A status write with bit 0 = 1 leaves it unchanged. Bits 7:1 read 0.
- R11: `rst_n` low returns `ctrl_q` to 7Fh (enable cleared) and clears the prescaler.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| por_n | input | 1 | Power-on reset, active low, clears everything |
| rst_n | input | 1 | System reset, active low, clears all but the status flag |
| wr_ctrl | input | 1 | Control byte write strobe |
| wr_stat | input | 1 | Status byte write strobe |
| wdata | input | 8 | Write data for either register |
| halt_stb | input | 1 | HALT instruction executed |
| hw_opt | input | 1 | Static hardware-watchdog option, forces the watchdog active |
| ctrl_q | output | 8 | Control readback: enable in bit 7, count in bits 6:0 |
| stat_q | output | 8 | Status readback: flag in bit 0 |
| wdg_rst | output | 1 | System reset request pulse |

## Verification
The embedded assertions check, on every cycle, the properties that relate adjacent cycles: the enable never falls outside reset, the count holds while inactive and drops by exactly one on each prescaler step, and every trigger (expiry, software write, HALT) is followed by a request. They also check that a request always sets the flag. The directed scenarios cover what needs a full run or a reset sequence: the exact timeout at both ends of the refresh range, the survival of the flag through a system reset and its loss at power-on, refreshes that keep the chip alive, and triggers that must do nothing while the watchdog is disabled.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned CNT_W = 7;
  localparam logic [CNT_W-1:0] CNT_RST = 7'h7F;
  localparam logic [CNT_W-1:0] CNT_EXPIRE = 7'h40;

  typedef struct packed {
    logic             en;
    logic [CNT_W-1:0] t;
  } ctrl_t;
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int unsigned PRESCALE = 12288
) (
  input  logic clk,
  input  logic arst_n,
  input  logic run,
  input  logic clr,
  output logic tick
);
  localparam int unsigned PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);

  logic [PW-1:0] pre_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)              pre_q <= '0;
    else if (clr || !run)     pre_q <= '0;
    else if (pre_q == LAST)   pre_q <= '0;
    else                      pre_q <= pre_q + 1'b1;
  end

  assign tick = run && !clr && (pre_q == LAST);

  a_r11_idle_zero: assert property (@(posedge clk) disable iff (!arst_n)
    (!run) |=> (pre_q == '0));
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
  import wdt_pkg::*;
(
  input  logic  clk,
  input  logic  arst_n,
  input  logic  wr,
  input  ctrl_t wdata,
  input  logic  active,
  input  logic  tick,
  output ctrl_t ctrl
);
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      ctrl.en <= 1'b0;
      ctrl.t  <= CNT_RST;
    end else if (wr) begin
      ctrl.en <= ctrl.en | wdata.en;
      ctrl.t  <= wdata.t;
    end else if (active && tick) begin
      ctrl.t  <= ctrl.t - 1'b1;
    end
  end

  a_r2_en_sticky: assert property (@(posedge clk) disable iff (!arst_n)
    ctrl.en |=> ctrl.en);
  a_r3_hold_idle: assert property (@(posedge clk) disable iff (!arst_n)
    (!active && !wr) |=> $stable(ctrl.t));
  a_r4_one_step: assert property (@(posedge clk) disable iff (!arst_n)
    (active && tick && !wr) |=> (ctrl.t == $past(ctrl.t) - 7'd1));
endmodule

// File: rtl/wdt_flag.sv
module wdt_flag (
  input  logic clk,
  input  logic por_n,
  input  logic req,
  input  logic wr,
  input  logic wbit,
  output logic flag
);
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)          flag <= 1'b0;
    else if (req)        flag <= 1'b1;
    else if (wr && !wbit) flag <= 1'b0;
  end

  a_r10_set_on_req: assert property (@(posedge clk) disable iff (!por_n)
    req |=> flag);
  a_r10_keep_on_one: assert property (@(posedge clk) disable iff (!por_n)
    (flag && !(wr && !wbit)) |=> flag);
endmodule

// File: rtl/wdt_downcount.sv
module wdt_downcount
  import wdt_pkg::*;
#(
  parameter int unsigned PRESCALE = 12288
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       rst_n,
  input  logic       wr_ctrl,
  input  logic       wr_stat,
  input  logic [7:0] wdata,
  input  logic       halt_stb,
  input  logic       hw_opt,
  output logic [7:0] ctrl_q,
  output logic [7:0] stat_q,
  output logic       wdg_rst
);
  logic  sys_n;
  logic  active;
  logic  tick;
  logic  flag;
  ctrl_t ctrl;
  ctrl_t wr_val;
  logic  expire, sw_rst, halt_rst, req_d;

  assign sys_n  = por_n & rst_n;
  assign wr_val = ctrl_t'(wdata);
  assign active = ctrl.en | hw_opt;

  wdt_prescaler #(.PRESCALE(PRESCALE)) u_pre (
    .clk(clk), .arst_n(sys_n), .run(active), .clr(wr_ctrl), .tick(tick)
  );

  wdt_counter u_cnt (
    .clk(clk), .arst_n(sys_n), .wr(wr_ctrl), .wdata(wr_val),
    .active(active), .tick(tick), .ctrl(ctrl)
  );

  assign expire   = active && tick && !wr_ctrl && (ctrl.t == CNT_EXPIRE);
  assign sw_rst   = wr_ctrl && (ctrl.en || wr_val.en || hw_opt) && !wr_val.t[CNT_W-1];
  assign halt_rst = halt_stb && active;
  assign req_d    = expire | sw_rst | halt_rst;

  always_ff @(posedge clk or negedge sys_n) begin
    if (!sys_n) wdg_rst <= 1'b0;
    else        wdg_rst <= req_d;
  end

  wdt_flag u_flag (
    .clk(clk), .por_n(por_n), .req(wdg_rst), .wr(wr_ctrl ? 1'b0 : wr_stat),
    .wbit(wdata[0]), .flag(flag)
  );

  assign ctrl_q = ctrl;
  assign stat_q = {7'b0, flag};

  a_r5_expire_req: assert property (@(posedge clk) disable iff (!sys_n)
    (active && tick && !wr_ctrl && ctrl_q[6:0] == 7'h40) |=> wdg_rst);
  a_r6_sw_req: assert property (@(posedge clk) disable iff (!sys_n)
    (wr_ctrl && wdata[7] && !wdata[6]) |=> wdg_rst);
  a_r7_halt_req: assert property (@(posedge clk) disable iff (!sys_n)
    (halt_stb && (ctrl_q[7] || hw_opt)) |=> wdg_rst);
  a_r7_halt_idle: assert property (@(posedge clk) disable iff (!sys_n)
    (halt_stb && !ctrl_q[7] && !hw_opt && !wr_ctrl) |=> !wdg_rst);
endmodule

// File: tb/test_wdt_downcount.sv
module test_wdt_downcount;
  localparam int unsigned PS = 4;

  logic clk = 0, por_n = 0, rst_n = 0;
  logic wr_ctrl = 0, wr_stat = 0, halt_stb = 0, hw_opt = 0;
  logic [7:0] wdata = 0;
  logic [7:0] ctrl_q, stat_q;
  logic wdg_rst;
  int n_chk = 0, n_bad = 0, pulses = 0;

  wdt_downcount #(.PRESCALE(PS)) i_wdt_downcount (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .wr_stat(wr_stat),
    .wdata(wdata), .halt_stb(halt_stb), .hw_opt(hw_opt),
    .ctrl_q(ctrl_q), .stat_q(stat_q), .wdg_rst(wdg_rst)
  );

  always #5 clk = ~clk;
  always @(negedge clk) if (wdg_rst) pulses++;

  task automatic check(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wr_c(input logic [7:0] v);
    @(negedge clk); wr_ctrl = 1; wdata = v;
    @(posedge clk);
    @(negedge clk); wr_ctrl = 0;
  endtask

  task automatic wr_s(input logic [7:0] v);
    @(negedge clk); wr_stat = 1; wdata = v;
    @(posedge clk);
    @(negedge clk); wr_stat = 0;
  endtask

  task automatic sys_reset();
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic wait_pulse(output int k);
    k = 0;
    for (int i = 1; i <= 3000; i++) begin
      @(posedge clk); @(negedge clk);
      if (wdg_rst) begin k = i; break; end
    end
  endtask

  task automatic t_reset();
    check("R1 ctrl", ctrl_q, 8'h7F);
    check("R1 stat", stat_q, 8'h00);
    check("R1 req", wdg_rst, 0);
  endtask

  task automatic t_disabled();
    int p0;
    p0 = pulses;
    wr_c(8'h40);
    check("R3 load", ctrl_q, 8'h40);
    repeat (50) @(negedge clk);
    check("R3 hold idle", ctrl_q, 8'h40);
    wr_c(8'h00);
    repeat (3) @(negedge clk);
    check("R6 no req when disabled", pulses - p0, 0);
    sys_reset();
  endtask

  task automatic t_min_timeout();
    int k;
    wr_c(8'hC0);
    wait_pulse(k);
    check("R5 C0h timeout", k, PS * 1);
    @(negedge clk);
    check("R9 single pulse", wdg_rst, 0);
    check("R10 flag set", stat_q, 8'h01);
    sys_reset();
    check("R11 ctrl after sysreset", ctrl_q, 8'h7F);
    check("R10 flag survives sysreset", stat_q, 8'h01);
  endtask

  task automatic t_step_and_max();
    int k;
    wr_c(8'hFF);
    repeat (PS) @(posedge clk);
    @(negedge clk);
    check("R4 first step", ctrl_q, 8'hFE);
    wr_c(8'h7F);
    check("R2 enable sticky", ctrl_q, 8'hFF);
    wait_pulse(k);
    check("R5 FFh timeout", k, PS * 64);
    sys_reset();
    check("R11 enable cleared", ctrl_q[7], 0);
  endtask

  task automatic t_refresh_sw();
    int p0;
    p0 = pulses;
    wr_c(8'hFF);
    for (int i = 0; i < 5; i++) begin
      repeat (200) @(negedge clk);
      wr_c(8'hFF);
    end
    check("R3 refresh keeps alive", pulses - p0, 0);
    wr_c(8'h80);
    check("R6 software reset", wdg_rst, 1);
    sys_reset();
  endtask

  task automatic t_halt();
    @(negedge clk); halt_stb = 1;
    @(posedge clk); @(negedge clk); halt_stb = 0;
    check("R7 halt while disabled", wdg_rst, 0);
    wr_c(8'hFF);
    @(negedge clk); halt_stb = 1;
    @(posedge clk); @(negedge clk); halt_stb = 0;
    check("R7 halt while enabled", wdg_rst, 1);
    sys_reset();
  endtask

  task automatic t_hwopt();
    int k;
    hw_opt = 1;
    wr_c(8'h45);
    check("R8 enable bit reads 0", ctrl_q, 8'h45);
    wait_pulse(k);
    check("R8 forced timeout", k, PS * 6);
    sys_reset();
    hw_opt = 0;
  endtask

  task automatic t_flag();
    wr_s(8'h01);
    check("R10 write 1 keeps", stat_q, 8'h01);
    wr_s(8'h00);
    check("R10 write 0 clears", stat_q, 8'h00);
    wr_c(8'h80);
    @(negedge clk);
    check("R10 set again", stat_q, 8'h01);
    sys_reset();
    @(negedge clk); por_n = 0;
    @(negedge clk); por_n = 1;
    @(negedge clk);
    check("R10 por clears", stat_q, 8'h00);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    por_n = 1; rst_n = 1;
    @(negedge clk);
    t_reset();
    t_disabled();
    t_min_timeout();
    t_step_and_max();
    t_refresh_sw();
    t_halt();
    t_hwopt();
    t_flag();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule